// File: doc/BRIEF.md
# Receive Subaddress Double-Buffer Controller

This block keeps one lookup pointer per receive (or broadcast) subaddress and uses it to run a ping-pong pair of 32-word data blocks for each one. While a message is arriving, the controller gives the data address for each incoming word. That address is the subaddress's active block base with the word index in the low five bits. When the message ends validly and the subaddress is in double-buffer mode, the pointer flips its block-select bit (bit 5). The block that was just filled becomes the inactive one, and it then holds the newest complete data.

The host reads two values for any subaddress: the active pointer, and the latest-data pointer, which is the active pointer with bit 5 inverted. The host also writes a one-bit mode per subaddress: 1 selects double-buffer mode, 0 selects single-message mode. To read the newest data without a race, the host drops the subaddress to single-message mode, which freezes the pointer. It then reads the latest-data pointer and its block, and finally restores double-buffer mode. After reset, subaddress s has its active pointer at s·64, so each subaddress owns a 64-word region and its two blocks start at s·64 and s·64+32.

Top module: `dbuf_rx_ctrl`

## Requirements
- R1: After reset, every subaddress s reads back an active pointer of s·64 (16 bits), and every subaddress is in single-message mode (mode bit 0).
- R2: A message end with msg_valid=1 and msg_rx=1, on a subaddress whose mode bit is 1, inverts bit 5 of that subaddress's active pointer at the next clock edge and leaves its other bits unchanged.
- R3: A message end with msg_valid=0 leaves the pointer unchanged.
- R4: A valid receive message end on a subaddress whose mode bit is 0 leaves the pointer unchanged.
- R5: A message end with msg_rx=0 (transmit) leaves the pointer unchanged.
- R6: host_latest_ptr always equals host_active_ptr with bit 5 inverted, for the subaddress on host_rd_sa.
- R7: data_addr equals bits 15..5 of msg_sa's active pointer, with word_idx in bits 4..0. Word index 31 therefore stays inside the active block.
- R8: A mode write takes effect from the next message end onward. A message end in the same cycle as a mode write to the same subaddress uses the old mode.
- R9: A swap changes only the pointer of the subaddress on msg_sa. All other pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_en | input | 1 | Host mode write strobe |
| mode_wr_sa | input | 5 | Subaddress being written |
| mode_wr_dbl | input | 1 | 1 = double-buffer mode, 0 = single-message mode |
| msg_sa | input | 5 | Subaddress of the current message |
| msg_rx | input | 1 | 1 = receive/broadcast message, 0 = transmit |
| msg_end | input | 1 | One-cycle message completion strobe |
| msg_valid | input | 1 | Message was valid, sampled with msg_end |
| word_idx | input | 5 | Index of the incoming data word |
| data_addr | output | 16 | Address of the incoming data word |
| host_rd_sa | input | 5 | Subaddress the host reads |
| host_active_ptr | output | 16 | Active pointer of host_rd_sa |
| host_latest_ptr | output | 16 | Base of the block holding the newest valid data |

## Verification
The swap decision is tried with these message ends:
- valid receive messages in double-buffer mode, to show the toggle and that a second swap toggles back;
- invalid messages, to separate validity gating from mode gating;
- transmit messages, to separate direction gating from the other two;
- valid messages in single-message mode, both before a subaddress is enabled and during the host's freeze-and-read sequence.

A mode write in the same cycle as a message end shows whether the mode is sampled before or after the write. Reads of untouched subaddresses and data addresses for word indexes 0 and 31 show that a swap stays local and that words stay inside their block.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int unsigned DB_SA_W = 5;
  typedef logic [DB_SA_W-1:0] sa_idx_t;

  typedef struct packed {
    logic    done;
    logic    ok;
    logic    rx;
    sa_idx_t sa;
  } msg_evt_t;
endpackage

// File: rtl/dbuf_mode_reg.sv
module dbuf_mode_reg
  import dbuf_pkg::*;
#(
  parameter int unsigned NUM_SA = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sa_idx_t           wr_sa,
  input  logic              wr_dbl,
  output logic [NUM_SA-1:0] mode_vec
);
  logic [NUM_SA-1:0] mode_q;
  logic [NUM_SA-1:0] mode_d;
  logic              mode_ce;

  always_comb begin
    mode_d  = mode_q;
    mode_ce = wr_en && (32'(wr_sa) < NUM_SA);
    if (mode_ce) mode_d[wr_sa] = wr_dbl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_ce) mode_q <= mode_d;
  end

  assign mode_vec = mode_q;

  a_r8_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_sa) < NUM_SA)) |=> (mode_q[$past(wr_sa)] == $past(wr_dbl)));
endmodule

// File: rtl/dbuf_swap_ctrl.sv
module dbuf_swap_ctrl
  import dbuf_pkg::*;
#(
  parameter int unsigned NUM_SA = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  msg_evt_t          evt,
  input  logic [NUM_SA-1:0] mode_vec,
  output logic [NUM_SA-1:0] swap_vec
);
  logic qualify;

  always_comb begin
    qualify  = evt.done && evt.ok && evt.rx && (32'(evt.sa) < NUM_SA);
    swap_vec = '0;
    if (qualify) swap_vec[evt.sa] = mode_vec[evt.sa];
  end

  a_r3_invalid_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.done && !evt.ok) |-> (swap_vec == '0));
  a_r5_tx_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.rx) |-> (swap_vec == '0));
  a_r9_one_swap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(swap_vec));
endmodule

// File: rtl/dbuf_ptr_bank.sv
module dbuf_ptr_bank
  import dbuf_pkg::*;
#(
  parameter int unsigned NUM_SA = 32,
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SA-1:0] swap_vec,
  input  sa_idx_t           host_sa,
  input  sa_idx_t           msg_sa,
  output logic [PTR_W-1:0]  host_ptr,
  output logic [PTR_W-1:0]  msg_ptr
);
  localparam logic [PTR_W-1:0] TOG_MASK = PTR_W'(1) << OFF_W;
  localparam int unsigned      REGION_SH = OFF_W + 1;

  logic [PTR_W-1:0] ptr_q [NUM_SA];
  logic [PTR_W-1:0] ptr_d [NUM_SA];

  for (genvar i = 0; i < NUM_SA; i++) begin : g_sa
    localparam logic [PTR_W-1:0] RST_PTR = PTR_W'(i) << REGION_SH;

    always_comb ptr_d[i] = ptr_q[i] ^ TOG_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ptr_q[i] <= RST_PTR;
      else if (swap_vec[i]) ptr_q[i] <= ptr_d[i];
    end

    a_r2_flip_bit: assert property (@(posedge clk) disable iff (!rst_n)
      swap_vec[i] |=> (ptr_q[i] == ($past(ptr_q[i]) ^ TOG_MASK)));
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !swap_vec[i] |=> $stable(ptr_q[i]));
  end

  always_comb begin
    host_ptr = '0;
    msg_ptr  = '0;
    if (32'(host_sa) < NUM_SA) host_ptr = ptr_q[host_sa];
    if (32'(msg_sa)  < NUM_SA) msg_ptr  = ptr_q[msg_sa];
  end
endmodule

// File: rtl/dbuf_addr_gen.sv
module dbuf_addr_gen #(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned OFF_W = 5
) (
  input  logic [PTR_W-1:0] msg_ptr,
  input  logic [OFF_W-1:0] word_idx,
  input  logic [PTR_W-1:0] host_ptr,
  output logic [PTR_W-1:0] data_addr,
  output logic [PTR_W-1:0] latest_ptr
);
  localparam logic [PTR_W-1:0] TOG_MASK = PTR_W'(1) << OFF_W;

  always_comb begin
    data_addr  = {msg_ptr[PTR_W-1:OFF_W], word_idx};
    latest_ptr = host_ptr ^ TOG_MASK;
  end
endmodule

// File: rtl/dbuf_rx_ctrl.sv
module dbuf_rx_ctrl
  import dbuf_pkg::*;
#(
  parameter int unsigned NUM_SA = 32,
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned OFF_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr_en,
  input  logic [4:0]       mode_wr_sa,
  input  logic             mode_wr_dbl,
  input  logic [4:0]       msg_sa,
  input  logic             msg_rx,
  input  logic             msg_end,
  input  logic             msg_valid,
  input  logic [OFF_W-1:0] word_idx,
  output logic [PTR_W-1:0] data_addr,
  input  logic [4:0]       host_rd_sa,
  output logic [PTR_W-1:0] host_active_ptr,
  output logic [PTR_W-1:0] host_latest_ptr
);
  localparam logic [PTR_W-1:0] TOG_MASK = PTR_W'(1) << OFF_W;

  msg_evt_t          evt;
  logic [NUM_SA-1:0] mode_vec;
  logic [NUM_SA-1:0] swap_vec;
  logic [PTR_W-1:0]  msg_ptr;

  always_comb begin
    evt.done = msg_end;
    evt.ok   = msg_valid;
    evt.rx   = msg_rx;
    evt.sa   = msg_sa;
  end

  dbuf_mode_reg #(.NUM_SA(NUM_SA)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_wr_en), .wr_sa(mode_wr_sa),
    .wr_dbl(mode_wr_dbl), .mode_vec(mode_vec)
  );

  dbuf_swap_ctrl #(.NUM_SA(NUM_SA)) u_swap (
    .clk(clk), .rst_n(rst_n), .evt(evt), .mode_vec(mode_vec), .swap_vec(swap_vec)
  );

  dbuf_ptr_bank #(.NUM_SA(NUM_SA), .PTR_W(PTR_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .swap_vec(swap_vec), .host_sa(host_rd_sa),
    .msg_sa(msg_sa), .host_ptr(host_active_ptr), .msg_ptr(msg_ptr)
  );

  dbuf_addr_gen #(.PTR_W(PTR_W), .OFF_W(OFF_W)) u_addr (
    .msg_ptr(msg_ptr), .word_idx(word_idx), .host_ptr(host_active_ptr),
    .data_addr(data_addr), .latest_ptr(host_latest_ptr)
  );

  a_r6_latest_partner: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_latest_ptr ^ host_active_ptr) == TOG_MASK));
  a_r7_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_sa == msg_sa) |->
      (data_addr[PTR_W-1:OFF_W] == host_active_ptr[PTR_W-1:OFF_W]));
  a_r4_single_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end && msg_valid && msg_rx && (host_rd_sa == msg_sa) && !mode_vec[msg_sa])
      |=> $stable(host_active_ptr));
endmodule

// File: tb/sim_dbuf_rx_ctrl.sv
module sim_dbuf_rx_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wr_en, mode_wr_dbl, msg_rx, msg_end, msg_valid;
  logic [4:0]  mode_wr_sa, msg_sa, host_rd_sa, word_idx;
  logic [15:0] data_addr, host_active_ptr, host_latest_ptr;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dbuf_rx_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_wr_sa(mode_wr_sa),
    .mode_wr_dbl(mode_wr_dbl), .msg_sa(msg_sa), .msg_rx(msg_rx), .msg_end(msg_end),
    .msg_valid(msg_valid), .word_idx(word_idx), .data_addr(data_addr),
    .host_rd_sa(host_rd_sa), .host_active_ptr(host_active_ptr),
    .host_latest_ptr(host_latest_ptr)
  );

  // op 0 = mode write (en = new mode), op 1 = message end (valid, rx)
  typedef struct packed {
    logic        op;
    logic [4:0]  sa;
    logic        valid;
    logic        rx;
    logic        en;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd3,  1'b0, 1'b0, 1'b1, 16'h00C0},  // R8 enable sa3
    '{1'b1, 5'd3,  1'b1, 1'b1, 1'b0, 16'h00E0},  // R2 swap
    '{1'b1, 5'd3,  1'b0, 1'b1, 1'b0, 16'h00E0},  // R3 invalid
    '{1'b1, 5'd3,  1'b1, 1'b1, 1'b0, 16'h00C0},  // R2 swap back
    '{1'b1, 5'd3,  1'b1, 1'b0, 1'b0, 16'h00C0},  // R5 transmit
    '{1'b1, 5'd30, 1'b1, 1'b1, 1'b0, 16'h0780},  // R4 single mode
    '{1'b0, 5'd30, 1'b0, 1'b0, 1'b1, 16'h0780},  // R8 enable sa30
    '{1'b1, 5'd30, 1'b1, 1'b1, 1'b0, 16'h07A0},  // R2 swap
    '{1'b0, 5'd3,  1'b0, 1'b0, 1'b0, 16'h00C0},  // R4 freeze sa3
    '{1'b1, 5'd3,  1'b1, 1'b1, 1'b0, 16'h00C0},  // R4 frozen
    '{1'b0, 5'd3,  1'b0, 1'b0, 1'b1, 16'h00C0},  // R8 re-enable
    '{1'b1, 5'd3,  1'b1, 1'b1, 1'b0, 16'h00E0}   // R2 swap again
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    mode_wr_en = 1'b0; mode_wr_sa = '0; mode_wr_dbl = 1'b0;
    msg_end = 1'b0; msg_valid = 1'b0; msg_rx = 1'b0;
  endtask

  task automatic rd(input logic [4:0] sa, output logic [15:0] act);
    host_rd_sa = sa;
    #1 act = host_active_ptr;
  endtask

  initial begin
    logic [15:0] v;
    idle();
    msg_sa = '0; host_rd_sa = '0; word_idx = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset pointers
    for (int s = 0; s < 32; s += 7) begin
      rd(5'(s), v);
      chk("R1", v, 16'(s * 64));
    end
    // R1 all single-message: valid messages on sa7 do not swap
    msg_sa = 5'd7; msg_end = 1'b1; msg_valid = 1'b1; msg_rx = 1'b1;
    @(negedge clk); idle();
    rd(5'd7, v); chk("R1", v, 16'h01C0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].op == 1'b0) begin
        mode_wr_en = 1'b1; mode_wr_sa = VECS[k].sa; mode_wr_dbl = VECS[k].en;
      end else begin
        msg_sa = VECS[k].sa; msg_end = 1'b1;
        msg_valid = VECS[k].valid; msg_rx = VECS[k].rx;
      end
      @(negedge clk); idle();
      rd(VECS[k].sa, v);
      chk("R2/R3/R4/R5/R8 table", v, VECS[k].exp);
      chk("R6", host_latest_ptr, VECS[k].exp ^ 16'h0020);
    end

    // R9 neighbours untouched
    rd(5'd4, v);  chk("R9", v, 16'h0100);
    rd(5'd0, v);  chk("R9", v, 16'h0000);
    rd(5'd31, v); chk("R9", v, 16'h07C0);

    // R7 data address within sa3 active block (0x00E0)
    msg_sa = 5'd3; word_idx = 5'd31;
    #1 chk("R7", data_addr, 16'h00FF);
    word_idx = 5'd0;
    #1 chk("R7", data_addr, 16'h00E0);
    msg_sa = 5'd30; word_idx = 5'd17;
    #1 chk("R7", data_addr, 16'h07B1);

    // R8 same-cycle mode write and message end on sa5
    @(negedge clk);
    mode_wr_en = 1'b1; mode_wr_sa = 5'd5; mode_wr_dbl = 1'b1;
    msg_sa = 5'd5; msg_end = 1'b1; msg_valid = 1'b1; msg_rx = 1'b1;
    @(negedge clk); idle();
    rd(5'd5, v); chk("R8 same cycle", v, 16'h0140);
    msg_sa = 5'd5; msg_end = 1'b1; msg_valid = 1'b1; msg_rx = 1'b1;
    @(negedge clk); idle();
    rd(5'd5, v); chk("R8 next message", v, 16'h0160);
    chk("R6", host_latest_ptr, 16'h0140);

    // R3 invalid on sa5 keeps pointer
    msg_sa = 5'd5; msg_end = 1'b1; msg_valid = 1'b0; msg_rx = 1'b1;
    @(negedge clk); idle();
    rd(5'd5, v); chk("R3", v, 16'h0160);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule